// File: doc/BRIEF.md
# Pulsed Line Code Transceiver

This block converts a serial bus bit stream to and from a pulse line code suited to optical or radio links. On the transmit side a dominant bit (0) is sent as a short low pulse at the start of its bit period, and a recessive bit (1) leaves the line high for the whole period. On the receive side the block looks for falling edges rather than line levels. A bit window holding a falling edge decodes as dominant, and an empty window decodes as recessive.

Timing comes from a programmable clock prescaler and a bit length counted in prescaled ticks. The receive window timer restarts on the first edge seen after idle, so later windows stay aligned with the sender. An optical transceiver cannot hear its own emission. For that reason the transmitted stream is looped back inside the block and combined, as a wired-AND, with receive input 0. The other receive inputs and the external input selection are bypassed. The frame layer above feeds bits through `txEn`/`txBit`/`txTake` and collects decoded bits from `rxValid`/`rxBit`. The bit period, tick count times prescaled clock, must be at least 1 µs, which sets the 1 Mbit/s line-rate ceiling, and `ticksPerBit` must be at least 3.

Top module: `pulseLineCodec`

## Requirements
- R1: A dominant bit (`txBit`=0) drives `txLine` low for exactly 2·(`prescaleDiv`+1) clock cycles, starting in the first cycle of its bit period.
- R2: A recessive bit (`txBit`=1) keeps `txLine` high for its whole bit period. Every bit period lasts `ticksPerBit`·(`prescaleDiv`+1) clock cycles, and consecutive bits follow with no gap.
- R3: `txTake` is high in the cycle in which `txBit` is consumed. This happens at once when the transmitter is idle and `txEn` is high, and in the last cycle of the current bit while a stream runs. If `txEn` is low at the end of a bit, the transmitter goes idle with `txLine` high.
- R4: A receive window that contains a detected falling edge yields `rxBit`=0, and a window without one yields `rxBit`=1. Each result is flagged by a one-cycle `rxValid` pulse in the cycle after the window's last cycle. `rxBit` holds its value between pulses.
- R5: The receive line passes through a two-flop synchronizer, and a falling edge is detected two cycles after the line falls. The first edge detected while idle opens a window in that same cycle. Every window lasts one bit period, and an edge that falls in a window's first cycle belongs to that window.
- R6: The receive source is `rxLine[0]` AND `txLine`, so the block decodes its own transmission. Where it transmits recessive while a remote sender is dominant, the bit decodes as dominant.
- R7: `rxSelIn` and `rxLine[NUM_RX-1:1]` have no effect on any output.
- R8: After `IDLE_RUN` consecutive recessive windows the receiver goes idle and raises no `rxValid` until the next falling edge.
- R9: During and right after reset, `txLine`=1, `rxValid`=0 and `rxBit`=1, and with `txEn` low `txTake`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescaleDiv | input | DIV_W | Prescaler ratio minus one (a tick every prescaleDiv+1 clocks) |
| ticksPerBit | input | BIT_W | Prescaled ticks per bit period (at least 3) |
| txEn | input | 1 | Transmit stream request |
| txBit | input | 1 | Next bit to send, 0 dominant, 1 recessive |
| txTake | output | 1 | txBit consumed this cycle |
| txLine | output | 1 | Pulse-coded line output |
| rxLine | input | NUM_RX | Receive inputs, only bit 0 is used |
| rxSelIn | input | SEL_W | External receive-input choice, bypassed |
| rxValid | output | 1 | One-cycle strobe for a decoded bit |
| rxBit | output | 1 | Decoded bit, 0 dominant, 1 recessive |

## Verification
The bench builds the block with DIV_W=4, BIT_W=5, NUM_RX=3 and IDLE_RUN=4. The short idle run lets the return to idle occur inside each short frame, including a return in the middle of a frame followed by a fresh restart. At run time it uses three settings. With no prescaling and 3 ticks per bit, a dominant pulse fills two of three cycles and each next edge lands in the first cycle of a window. A ratio of 3 with 5 ticks and a ratio of 2 with 8 ticks stretch the pulse across prescaled ticks. Two inputs are randomised on every cycle: the two unused receive inputs and the selection input. A remote sender is placed at a phase offset to the local transmitter, and in one frame it overlaps the local sender on the wired-AND.

// File: rtl/plcPkg.sv
package plcPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txPreClr;
    logic txActive;
    logic rxStart;
    logic rxRun;
    logic rxEmit;
  } plcStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic txTick;
    logic txLast;
    logic rxFall;
    logic rxLast;
    logic rxSawFall;
  } plcStatus_t;

endpackage

// File: rtl/plcPrescaler.sv
module plcPrescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/plcDatapath.sv
module plcDatapath
  import plcPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int BIT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] prescaleDiv,
  input  logic [BIT_W-1:0] ticksPerBit,
  input  logic             txBit,
  input  logic             rxLine0,
  input  plcStrobe_t       strobe,
  output plcStatus_t       status,
  output logic             txLine,
  output logic             rxValid,
  output logic             rxBit
);

  localparam int CNT_W     = DIV_W + BIT_W + 1;
  localparam int LOW_TICKS = 2;
  localparam int SYNC_N    = 3;

  // transmit timing
  logic             txTick;
  logic [BIT_W-1:0] txTickCnt;
  logic             txCur;

  plcPrescaler #(.DIV_W(DIV_W)) uTxPre (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobe.txPreClr),
    .div  (prescaleDiv),
    .tick (txTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txTickCnt <= '0;
      txCur     <= 1'b1;
    end else if (strobe.txLoad) begin
      txTickCnt <= '0;
      txCur     <= txBit;
    end else if (strobe.txActive && txTick) begin
      txTickCnt <= txTickCnt + BIT_W'(1);
    end
  end

  assign txLine = !(strobe.txActive && !txCur &&
                    (txTickCnt < BIT_W'(LOW_TICKS)));

  // receive source: line 0 wired-AND with own emission
  logic              srcLine;
  logic [SYNC_N-1:0] syncQ;
  logic              fall;

  assign srcLine = rxLine0 & txLine;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_N-2:0], srcLine};
  end

  assign fall = syncQ[SYNC_N-1] & ~syncQ[SYNC_N-2];

  // receive window in system clocks
  logic [CNT_W-1:0] bitLen;
  logic [CNT_W-1:0] rxCnt;
  logic             rxLast;
  logic             sawFall;

  assign bitLen = (CNT_W'(prescaleDiv) + CNT_W'(1)) * CNT_W'(ticksPerBit);
  assign rxLast = (rxCnt == bitLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt   <= '0;
      sawFall <= 1'b0;
    end else if (strobe.rxStart) begin
      rxCnt   <= CNT_W'(1);
      sawFall <= 1'b1;
    end else if (strobe.rxRun) begin
      if (rxLast) begin
        rxCnt   <= '0;
        sawFall <= fall;
      end else begin
        rxCnt   <= rxCnt + CNT_W'(1);
        sawFall <= sawFall | fall;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxBit   <= 1'b1;
    end else begin
      rxValid <= strobe.rxEmit;
      if (strobe.rxEmit) rxBit <= ~sawFall;
    end
  end

  always_comb begin
    status.txTick    = txTick;
    status.txLast    = (txTickCnt == ticksPerBit - BIT_W'(1));
    status.rxFall    = fall;
    status.rxLast    = rxLast;
    status.rxSawFall = sawFall;
  end

endmodule

// File: rtl/plcControl.sv
module plcControl
  import plcPkg::*;
#(
  parameter int IDLE_RUN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  plcStatus_t status,
  output plcStrobe_t strobe,
  output logic       txTake
);

  localparam int RUN_W = $clog2(IDLE_RUN + 1);

  logic             txActive;
  logic             rxActive;
  logic [RUN_W-1:0] runCnt;
  logic             txBitEnd;
  logic             recWin;
  logic             runFull;

  assign txBitEnd = txActive && status.txTick && status.txLast;
  assign txTake   = txEn && (!txActive || txBitEnd);

  always_comb begin
    strobe.txLoad   = txTake;
    strobe.txPreClr = txEn && !txActive;
    strobe.txActive = txActive;
    strobe.rxStart  = !rxActive && status.rxFall;
    strobe.rxRun    = rxActive;
    strobe.rxEmit   = rxActive && status.rxLast;
  end

  assign recWin  = strobe.rxEmit && !status.rxSawFall;
  assign runFull = (runCnt == RUN_W'(IDLE_RUN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
    end else if (!txActive && txEn) begin
      txActive <= 1'b1;
    end else if (txBitEnd && !txEn) begin
      txActive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      runCnt   <= '0;
    end else begin
      if (strobe.rxStart) rxActive <= 1'b1;
      else if (recWin && runFull && !status.rxFall) rxActive <= 1'b0;
      if (strobe.rxEmit) begin
        if (!recWin)     runCnt <= '0;
        else if (runFull) runCnt <= '0;
        else             runCnt <= runCnt + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/pulseLineCodec.sv
module pulseLineCodec
  import plcPkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int BIT_W    = 6,
  parameter int NUM_RX   = 3,
  parameter int IDLE_RUN = 8,
  localparam int SEL_W   = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  prescaleDiv,
  input  logic [BIT_W-1:0]  ticksPerBit,
  input  logic              txEn,
  input  logic              txBit,
  output logic              txTake,
  output logic              txLine,
  input  logic [NUM_RX-1:0] rxLine,
  input  logic [SEL_W-1:0]  rxSelIn,
  output logic              rxValid,
  output logic              rxBit
);

  plcStrobe_t strobe;
  plcStatus_t status;

  // pulse mode forces input 0; selection and the other inputs are bypassed
  generate
    if (NUM_RX > 1) begin : gBypass
      logic unusedInputs;
      assign unusedInputs = ^{rxSelIn, rxLine[NUM_RX-1:1]};
    end else begin : gBypassOne
      logic unusedInputs;
      assign unusedInputs = ^rxSelIn;
    end
  endgenerate

  plcControl #(.IDLE_RUN(IDLE_RUN)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .txEn   (txEn),
    .status (status),
    .strobe (strobe),
    .txTake (txTake)
  );

  plcDatapath #(.DIV_W(DIV_W), .BIT_W(BIT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .prescaleDiv (prescaleDiv),
    .ticksPerBit (ticksPerBit),
    .txBit       (txBit),
    .rxLine0     (rxLine[0]),
    .strobe      (strobe),
    .status      (status),
    .txLine      (txLine),
    .rxValid     (rxValid),
    .rxBit       (rxBit)
  );

endmodule

// File: rtl/pulseLineCodecChk.sv
module pulseLineCodecChk #(
  parameter int DIV_W = 8,
  parameter int BIT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] prescaleDiv,
  input logic [BIT_W-1:0] ticksPerBit,
  input logic             txBit,
  input logic             txTake,
  input logic             txLine,
  input logic             rxValid
);

  localparam int CNT_W = DIV_W + BIT_W + 1;
  localparam int GAP_W = CNT_W + 1;

  logic [CNT_W-1:0] lowRun;
  logic [GAP_W-1:0] gapCnt;
  logic [CNT_W-1:0] bitLen;
  logic [CNT_W-1:0] pulseLen;

  assign bitLen   = (CNT_W'(prescaleDiv) + CNT_W'(1)) * CNT_W'(ticksPerBit);
  assign pulseLen = (CNT_W'(prescaleDiv) + CNT_W'(1)) * CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rstN || txLine) lowRun <= '0;
    else                 lowRun <= lowRun + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 gapCnt <= '1;
    else if (txTake)           gapCnt <= GAP_W'(1);
    else if (gapCnt != '1)     gapCnt <= gapCnt + GAP_W'(1);
  end

  p_dom_pulse_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txLine) |-> lowRun == pulseLen);

  p_dom_starts_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txTake && !txBit) |=> !txLine);

  p_rec_stays_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txTake && txBit) |=> txLine);

  p_fall_at_bit_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> $past(txTake));

  p_take_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> gapCnt >= GAP_W'(bitLen));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

bind pulseLineCodec pulseLineCodecChk #(.DIV_W(DIV_W), .BIT_W(BIT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .prescaleDiv (prescaleDiv),
  .ticksPerBit (ticksPerBit),
  .txBit       (txBit),
  .txTake      (txTake),
  .txLine      (txLine),
  .rxValid     (rxValid)
);

// File: tb/pulseLineCodec_test.sv
module pulseLineCodec_test;

  localparam int DIV_W    = 4;
  localparam int BIT_W    = 5;
  localparam int NUM_RX   = 3;
  localparam int IDLE_RUN = 4;
  localparam int SEL_W    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DIV_W-1:0]  prescaleDiv = '0;
  logic [BIT_W-1:0]  ticksPerBit = BIT_W'(3);
  logic              txEn = 1'b0;
  logic              txBit = 1'b1;
  logic              txTake;
  logic              txLine;
  logic [NUM_RX-1:0] rxLine = '1;
  logic [SEL_W-1:0]  rxSelIn = '0;
  logic              rxValid;
  logic              rxBit;

  always #4 clk = ~clk;

  pulseLineCodec #(.DIV_W(DIV_W), .BIT_W(BIT_W), .NUM_RX(NUM_RX), .IDLE_RUN(IDLE_RUN)) uut (
    .clk(clk), .rstN(rstN), .prescaleDiv(prescaleDiv), .ticksPerBit(ticksPerBit),
    .txEn(txEn), .txBit(txBit), .txTake(txTake), .txLine(txLine),
    .rxLine(rxLine), .rxSelIn(rxSelIn), .rxValid(rxValid), .rxBit(rxBit)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // configuration and stimulus state
  int cDiv = 0, cTpb = 3, bitLen = 3, domLen = 2;
  int txQ[$];
  int remQ[$];
  int decQ[$];
  bit txOn = 0;
  int remDelay = 0;
  bit remAct = 0;
  int remCur = 1, remClk = 0;

  // reference model state
  bit mTxAct, mTxCur, mS1, mS2, mS3, mRxAct, mSaw, mRxValid, mRxBit;
  int mTxClk, mRxClk, mRun;

  task automatic modelReset();
    mTxAct = 0; mTxCur = 1; mTxClk = 0;
    mS1 = 1; mS2 = 1; mS3 = 1;
    mRxAct = 0; mRxClk = 0; mSaw = 0; mRun = 0;
    mRxValid = 0; mRxBit = 1;
  endtask

  // one clock: drive at negedge, compare, advance the model
  task automatic step();
    bit mLine, mTake, src, fall, nv, remLvl;
    @(negedge clk);
    txEn   = txOn && (txQ.size() > 0);
    txBit  = (txQ.size() > 0) ? txQ[0][0] : 1'b1;
    remLvl = !(remAct && remCur == 0 && remClk < domLen);
    rxLine[0]   = remLvl;
    rxLine[2:1] = 2'($urandom);   // R7: ignored inputs
    rxSelIn     = 2'($urandom);   // R7: bypassed selection
    #1;
    mLine = !(mTxAct && mTxCur == 0 && mTxClk < domLen);
    mTake = txEn && (!mTxAct || mTxClk == bitLen - 1);
    chk(txLine == mLine, mLine ? "R2" : "R1", "txLine", txLine, mLine);
    chk(txTake == mTake, "R3", "txTake", txTake, mTake);
    chk(rxValid == mRxValid, "R4", "rxValid", rxValid, mRxValid);
    chk(rxBit == mRxBit, "R4", "rxBit", rxBit, mRxBit);
    if (rxValid) decQ.push_back(int'(rxBit));
    src  = rxLine[0] & mLine;   // R6 loopback
    fall = mS3 && !mS2;         // R5 synchronised edge
    if (!rstN) begin
      modelReset();
    end else begin
      if (mTake) begin
        mTxAct = 1; mTxCur = txBit; mTxClk = 0;
        void'(txQ.pop_front());
      end else if (mTxAct) begin
        if (mTxClk == bitLen - 1) mTxAct = 0;
        else mTxClk++;
      end
      nv = 0;
      if (!mRxAct) begin
        if (fall) begin mRxAct = 1; mRxClk = 1; mSaw = 1; end
      end else if (mRxClk == bitLen - 1) begin
        nv = 1; mRxBit = !mSaw;
        if (mSaw) mRun = 0;
        else if (mRun == IDLE_RUN - 1) begin
          mRun = 0;
          if (!fall) mRxAct = 0;
        end else mRun++;
        mRxClk = 0; mSaw = fall;
      end else begin
        mRxClk++; mSaw = mSaw | fall;
      end
      mRxValid = nv;
      mS3 = mS2; mS2 = mS1; mS1 = src;
    end
    // remote sender
    if (remAct) begin
      if (remClk == bitLen - 1) begin
        if (remQ.size() > 0) begin remCur = remQ.pop_front(); remClk = 0; end
        else remAct = 0;
      end else remClk++;
    end else if (remQ.size() > 0) begin
      if (remDelay == 0) begin remAct = 1; remCur = remQ.pop_front(); remClk = 0; end
      else remDelay--;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
  endtask

  // expected decoded stream from the line bits (R4, R8)
  task automatic expDecode(input int bits[$], output int e[$]);
    bit act = 0;
    int run = 0;
    e.delete();
    foreach (bits[i]) begin
      if (!act) begin
        if (bits[i] == 0) begin act = 1; run = 0; e.push_back(0); end
      end else begin
        e.push_back(bits[i]);
        if (bits[i] != 0) begin
          run++;
          if (run == IDLE_RUN) begin act = 0; run = 0; end
        end else run = 0;
      end
    end
    while (act) begin
      e.push_back(1); run++;
      if (run == IDLE_RUN) act = 0;
    end
  endtask

  task automatic frame(input int d, input int t, input logic [31:0] txPat, input int txN,
                       input logic [31:0] remPat, input int remN, input int offs);
    int lineBits[$];
    int e[$];
    int n, cnt;
    string tag;
    cDiv = d; cTpb = t; bitLen = (d + 1) * t; domLen = 2 * (d + 1);
    prescaleDiv = DIV_W'(d); ticksPerBit = BIT_W'(t);
    txOn = 0;
    doReset();
    decQ.delete(); txQ.delete(); remQ.delete();
    remDelay = offs; remAct = 0;
    n = (txN > remN) ? txN : remN;
    for (int i = 0; i < n; i++) begin
      int tb = (i < txN) ? int'(txPat[txN-1-i]) : 1;
      int rb = (i < remN) ? int'(remPat[remN-1-i]) : 1;
      if (i < txN) txQ.push_back(tb);
      if (i < remN) remQ.push_back(rb);
      lineBits.push_back(tb & rb);  // R6 wired-AND of both senders
    end
    txOn = (txN > 0);
    repeat ((n + IDLE_RUN + 3) * bitLen + offs + 20) step();
    txOn = 0;
    expDecode(lineBits, e);
    tag = (txN > 0) ? "R6" : "R5";
    chk(decQ.size() == e.size(), tag, "decoded count", decQ.size(), e.size());
    foreach (e[i]) begin
      int got = (i < decQ.size()) ? decQ[i] : -1;
      chk(got == e[i], tag, "decoded bit", got, e[i]);
    end
    // R8 and R7: idle receiver stays quiet while unused inputs toggle
    cnt = 0;
    repeat (3 * bitLen) begin
      step();
      if (rxValid) cnt++;
    end
    chk(cnt == 0, "R8", "rxValid while idle", cnt, 0);
  endtask

  initial begin
    modelReset();
    doReset();
    // R9: reset values
    chk(txLine == 1'b1, "R9", "txLine after reset", txLine, 1);
    chk(rxValid == 1'b0, "R9", "rxValid after reset", rxValid, 0);
    chk(rxBit == 1'b1, "R9", "rxBit after reset", rxBit, 1);
    chk(txTake == 1'b0, "R9", "txTake after reset", txTake, 0);

    // loopback of own stream (R1 R2 R3 R6), minimum bit of 3 ticks
    frame(0, 3, 32'b01001101, 8, 32'b0, 0, 0);
    // remote sender with phase offset (R4 R5)
    frame(0, 3, 32'b0, 0, 32'b00101110, 8, 1);
    // prescaled ticks
    frame(2, 5, 32'b011101001, 9, 32'b0, 0, 0);
    frame(2, 5, 32'b0, 0, 32'b0110100, 7, 4);
    // leading recessive bits and a mid-frame idle run (R8)
    frame(1, 8, 32'b11010, 5, 32'b0, 0, 0);
    frame(1, 8, 32'b0111110, 7, 32'b0, 0, 0);
    // both senders on the wired-AND (R6)
    frame(1, 4, 32'b1011011, 7, 32'b0110101, 7, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule